// File: doc/BRIEF.md
# Root Hub Downstream Port Control and Status Register

This block holds the state of a single downstream port of a USB host root hub and presents it as one 32-bit register. The low half reports live port status. Each of its bit positions also acts as a command when software writes a 1 to it, and the command differs from what the bit reports on a read. The high half holds sticky change flags. Hardware events set them, and software clears a flag by writing a 1 to it.

Software drives the register through a simple write strobe with a data word. The read data is always visible. The surrounding hub logic supplies the device-presence, low-speed and overcurrent levels and a one-millisecond tick. It takes back the enable, suspend, reset and power controls. A port reset times itself in ticks, enables the port when it completes and reports completion through a change flag. The change-pending output feeds the hub interrupt.

Top module: `rh_port_reg`

## Requirements
- R1: After reset, every read bit is 0 and the enable, suspend, reset, power and change-pending outputs are 0.
- R2: Bit 0 reads the sampled device-presence level one clock after it changes. Any change of that level sets bit 16.
- R3: Writing 1 to bit 1 enables the port only while bit 0 reads 1. Otherwise the write is ignored. Writing 1 to bit 0 disables the port and clears suspend, without setting bit 17. Bit 1 reads the enable state.
- R4: Writing 1 to bit 2 suspends the port only while it is enabled. Writing 1 to bit 3 while suspended ends the suspend and sets bit 18. Bit 2 reads the suspend state.
- R5: Writing 1 to bit 4 while a device is present starts a port reset, and bit 4 reads 1. The reset ends on the RESET_MS-th millisecond tick after it starts. On that tick bit 4 clears, the port becomes enabled and bit 20 sets. A reset write with no device present is ignored.
- R6: Writing 1 to bit 8 turns port power on, and writing 1 to bit 9 turns it off. Bit 8 reads the power state. Bit 9 reads 1 when a device is present and the low-speed input is high.
- R7: Bit 3 reads the sampled overcurrent level. Any change of that level sets bit 19.
- R8: Writing 1 to a change bit (16 to 20) clears it. If a hardware event sets the same flag in that cycle, the set wins. Writing 0 to any bit has no effect.
- R9: When a device disconnects, the port loses enable and suspend, any running reset is aborted without setting bit 20, and bit 17 sets if the port was enabled.
- R10: Bits 5 to 7, 10 to 15 and 21 to 31 read 0. The change-pending output is 1 exactly when any of bits 16 to 20 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dev_present | input | 1 | Device attached on the port |
| dev_lowspeed | input | 1 | Attached device is low speed |
| ovc_in | input | 1 | Overcurrent detected on the port |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| port_enable | output | 1 | Port enabled |
| port_suspend | output | 1 | Port suspended |
| port_reset | output | 1 | Port reset signalling active |
| port_power | output | 1 | Port power switched on |
| change_pend | output | 1 | At least one change flag set |

## Verification
The command decoding is driven with a sequence of single-bit writes. Each write is tried both when its guard condition holds and when it does not, which separates a correctly gated enable or suspend from an ungated one. A zero-data write shows that writes act only on ones. A write that clears a change flag in the same cycle that its input toggles shows whether set or clear has priority. Ticks are counted across a reset to tell an exact RESET_MS-tick length from an off-by-one length. A disconnect in mid-reset separates an aborted reset from one that completes.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
   // bit positions in the register word (software decodes these)
   localparam int B_CONN  = 0;
   localparam int B_EN    = 1;
   localparam int B_SUSP  = 2;
   localparam int B_OC    = 3;
   localparam int B_RST   = 4;
   localparam int B_PWR   = 8;
   localparam int B_LS    = 9;
   localparam int B_CHG   = 16;
   localparam int NCHG    = 5;
   localparam int REG_W   = 32;

   // indices inside the change-flag vector
   localparam int C_CONN = 0;
   localparam int C_EN   = 1;
   localparam int C_SUSP = 2;
   localparam int C_OC   = 3;
   localparam int C_RST  = 4;

   typedef struct packed {
      logic            dis_port;
      logic            ena_port;
      logic            go_susp;
      logic            go_resume;
      logic            go_reset;
      logic            pwr_on;
      logic            pwr_off;
      logic [NCHG-1:0] chg_clr;
   } cmd_t;
endpackage

// File: rtl/rhp_cmd_dec.sv
module rhp_cmd_dec
   import rhp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output cmd_t              cmd
);
   generate
      if (DATA_W < B_CHG + NCHG) begin : g_bad_width
         $error("rhp_cmd_dec: DATA_W too small for change field");
      end
   endgenerate

   always_comb begin
      cmd.dis_port  = wr & wdata[B_CONN];
      cmd.ena_port  = wr & wdata[B_EN];
      cmd.go_susp   = wr & wdata[B_SUSP];
      cmd.go_resume = wr & wdata[B_OC];
      cmd.go_reset  = wr & wdata[B_RST];
      cmd.pwr_on    = wr & wdata[B_PWR];
      cmd.pwr_off   = wr & wdata[B_LS];
      cmd.chg_clr   = wr ? wdata[B_CHG +: NCHG] : '0;
   end
endmodule

// File: rtl/rhp_rst_timer.sv
module rhp_rst_timer #(
   parameter int RESET_MS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic tick,
   output logic active,
   output logic done
);
   localparam int CW = $clog2(RESET_MS + 1);

   generate
      if (RESET_MS < 1) begin : g_bad_len
         $error("rhp_rst_timer: RESET_MS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign done = active & tick & ~abort & (cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (abort) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         cnt    <= CW'(RESET_MS);
      end else if (active && tick) begin
         if (cnt == CW'(1)) begin
            active <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   // without a tick or abort a running reset keeps going
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick && !abort) |=> active);
   // completion ends the reset
   assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);
   // abort always stops it
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !active);
endmodule

// File: rtl/rhp_chg_bits.sv
module rhp_chg_bits #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rhp_chg_bits: N must be positive");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
         end

         assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
         assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
      end
   endgenerate
endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg
   import rhp_pkg::*;
#(
   parameter int RESET_MS = 10,
   parameter bit OC_TRACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             dev_present,
   input  logic             dev_lowspeed,
   input  logic             ovc_in,
   input  logic             ms_tick,
   output logic             port_enable,
   output logic             port_suspend,
   output logic             port_reset,
   output logic             port_power,
   output logic             change_pend
);
   cmd_t            cmd;
   logic            conn_q, ls_q, oc_q;
   logic            en_q, susp_q, pwr_q;
   logic            disc, rst_done, rst_act, rst_go;
   logic [NCHG-1:0] chg_set, chg;

   rhp_cmd_dec #(.DATA_W(REG_W)) u_dec (
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .cmd   (cmd)
   );

   assign disc   = conn_q & ~dev_present;
   assign rst_go = cmd.go_reset & conn_q;

   rhp_rst_timer #(.RESET_MS(RESET_MS)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (rst_go),
      .abort  (disc),
      .tick   (ms_tick),
      .active (rst_act),
      .done   (rst_done)
   );

   // sampled line levels
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_q <= 1'b0;
         ls_q   <= 1'b0;
      end else begin
         conn_q <= dev_present;
         ls_q   <= dev_lowspeed;
      end
   end

   logic oc_chg;
   generate
      if (OC_TRACK) begin : g_oc
         always_ff @(posedge clk) begin
            if (!rst_n) oc_q <= 1'b0;
            else        oc_q <= ovc_in;
         end
         assign oc_chg = oc_q ^ ovc_in;
      end else begin : g_no_oc
         assign oc_q   = 1'b0;
         assign oc_chg = 1'b0;
      end
   endgenerate

   // enable / suspend / power state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         susp_q <= 1'b0;
         pwr_q  <= 1'b0;
      end else begin
         if (disc)                          en_q <= 1'b0;
         else if (rst_done)                 en_q <= 1'b1;
         else if (cmd.dis_port)             en_q <= 1'b0;
         else if (cmd.ena_port && conn_q)   en_q <= 1'b1;

         if (disc || rst_done || cmd.dis_port) susp_q <= 1'b0;
         else if (cmd.go_resume && susp_q)     susp_q <= 1'b0;
         else if (cmd.go_susp && en_q)         susp_q <= 1'b1;

         if (cmd.pwr_off)     pwr_q <= 1'b0;
         else if (cmd.pwr_on) pwr_q <= 1'b1;
      end
   end

   always_comb begin
      chg_set         = '0;
      chg_set[C_CONN] = conn_q ^ dev_present;
      chg_set[C_EN]   = disc & en_q;
      chg_set[C_SUSP] = cmd.go_resume & susp_q & ~disc;
      chg_set[C_OC]   = oc_chg;
      chg_set[C_RST]  = rst_done;
   end

   rhp_chg_bits #(.N(NCHG)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (chg_set),
      .clr   (cmd.chg_clr),
      .flags (chg)
   );

   always_comb begin
      reg_rdata                 = '0;
      reg_rdata[B_CONN]         = conn_q;
      reg_rdata[B_EN]           = en_q;
      reg_rdata[B_SUSP]         = susp_q;
      reg_rdata[B_OC]           = oc_q;
      reg_rdata[B_RST]          = rst_act;
      reg_rdata[B_PWR]          = pwr_q;
      reg_rdata[B_LS]           = conn_q & ls_q;
      reg_rdata[B_CHG +: NCHG]  = chg;
   end

   assign port_enable  = en_q;
   assign port_suspend = susp_q;
   assign port_reset   = rst_act;
   assign port_power   = pwr_q;
   assign change_pend  = |chg;

   // enable only ever rises with a device present
   assert_en_conn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> conn_q);
   // suspend implies enabled
   assert_susp_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> en_q);
   // a new connection is flagged
   assert_conn_chg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conn_q) |-> chg[C_CONN]);
   // disconnect tears the port down
   assert_disc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conn_q) |-> (!en_q && !susp_q && !rst_act));
   // completed reset leaves the port enabled and flagged
   assert_rst_fin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rst_act) && conn_q) |-> (en_q && chg[C_RST]));
   // power-off command wins
   assert_pwr_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.pwr_off |=> !pwr_q);
endmodule

// File: tb/sim_rh_port_reg.sv
module sim_rh_port_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dev_present = 1'b0, dev_lowspeed = 1'b0, ovc_in = 1'b0, ms_tick = 1'b0;
   logic        port_enable, port_suspend, port_reset, port_power, change_pend;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rh_port_reg u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .dev_present(dev_present), .dev_lowspeed(dev_lowspeed),
      .ovc_in(ovc_in), .ms_tick(ms_tick), .port_enable(port_enable),
      .port_suspend(port_suspend), .port_reset(port_reset), .port_power(port_power),
      .change_pend(change_pend)
   );

   // {present, lowspeed, overcurrent, wr, wdata, expected rdata}
   localparam int NV = 18;
   localparam logic [67:0] VEC [NV] = '{
      {4'b0001, 32'h0000_0002, 32'h0000_0000}, // R3 enable ignored, no device
      {4'b0001, 32'h0000_0100, 32'h0000_0100}, // R6 power on
      {4'b1000, 32'h0000_0000, 32'h0001_0101}, // R2 connect
      {4'b1001, 32'h0001_0000, 32'h0000_0101}, // R8 clear connect change
      {4'b1001, 32'h0000_0002, 32'h0000_0103}, // R3 enable
      {4'b1001, 32'h0000_0004, 32'h0000_0107}, // R4 suspend
      {4'b1001, 32'h0000_0008, 32'h0004_0103}, // R4 resume
      {4'b1001, 32'h0004_0000, 32'h0000_0103}, // R8 clear
      {4'b1001, 32'h0000_0000, 32'h0000_0103}, // R8 zero write
      {4'b1010, 32'h0000_0000, 32'h0008_010B}, // R7 overcurrent
      {4'b1001, 32'h0008_0000, 32'h0008_0103}, // R8 set beats clear
      {4'b1001, 32'h0008_0000, 32'h0000_0103}, // R8 clear
      {4'b1001, 32'h0000_0001, 32'h0000_0101}, // R3 disable
      {4'b1100, 32'h0000_0000, 32'h0000_0301}, // R6 low speed
      {4'b1101, 32'h0000_0200, 32'h0000_0201}, // R6 power off
      {4'b1101, 32'h0000_0002, 32'h0000_0203}, // R3 enable
      {4'b0100, 32'h0000_0000, 32'h0003_0000}, // R9 disconnect
      {4'b0001, 32'h0003_0000, 32'h0000_0000}  // R8 clear both
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [31:0] exp);
      check(req, reg_rdata, exp);
      check({req, " R10 outputs"},
            {27'd0, port_power, port_reset, port_suspend, port_enable, change_pend},
            {27'd0, exp[8], exp[4], exp[2], exp[1], |exp[20:16]});
   endtask

   task automatic step(input logic p, input logic l, input logic o, input logic w,
                       input logic [31:0] d, input logic t);
      dev_present = p; dev_lowspeed = l; ovc_in = o;
      reg_wr = w; reg_wdata = d; ms_tick = t;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; ms_tick = 1'b0;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R1 reset", 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release", 32'h0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:32], 1'b0);
         check_all($sformatf("vector %0d", i), VEC[i][31:0]);
      end

      // R5 reset write ignored without device
      step(0, 0, 0, 1, 32'h10, 0);
      check_all("R5 no device", 32'h0);
      step(1, 0, 0, 0, 32'h0, 0);
      step(1, 0, 0, 1, 32'h0001_0000, 0);
      check_all("R2 connect cleared", 32'h1);

      // R5 timed reset
      step(1, 0, 0, 1, 32'h10, 0);
      check_all("R5 started", 32'h11);
      for (int k = 1; k < 10; k++) begin
         step(1, 0, 0, 0, 32'h0, 1);
         step(1, 0, 0, 0, 32'h0, 0);
         check_all($sformatf("R5 tick %0d", k), 32'h11);
      end
      step(1, 0, 0, 0, 32'h0, 1);
      check_all("R5 complete", 32'h0010_0003);
      step(1, 0, 0, 1, 32'h0010_0000, 0);
      check_all("R8 clear reset change", 32'h3);

      // R9 abort reset by disconnect
      step(1, 0, 0, 1, 32'h10, 0);
      check_all("R5 restart", 32'h13);
      for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 32'h0, 1);
      step(0, 0, 0, 0, 32'h0, 0);
      check_all("R9 abort", 32'h0003_0000);
      step(0, 0, 0, 1, 32'h0003_0000, 0);
      for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 32'h0, 1);
      check_all("R9 no completion after abort", 32'h0);

      // R4 suspend ignored when not enabled
      step(1, 0, 0, 0, 32'h0, 0);
      step(1, 0, 0, 1, 32'h0001_0004, 0);
      check_all("R4 suspend ignored", 32'h1);

      // R10 reserved bits
      step(1, 0, 0, 1, 32'hFFE0_FCE0, 0);
      check_all("R10 reserved write", 32'h1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule